// File: doc/BRIEF.md
# Speaker Gate and Refresh Status Port

This block is an 8-bit system control port that sits next to a three-channel interval timer. A host write sets two bits: the gate input of timer channel 2 and an enable for the speaker data path. Channels 0 and 1 keep their gates permanently high. A host read captures a status byte. That byte holds the two written bits, the live output level of timer channel 2, and a refresh indicator that the port generates itself.

The refresh indicator is a square wave made by dividing the system clock. Each level lasts `REFRESH_TERM` clock cycles. The default of 4096 cycles at a 4 ns clock gives a half-period of about 2^14 ns, which is close to 15 µs. The speaker drive output is the channel 2 output masked by the speaker enable bit. The timer channel itself lives outside this block.

The reset input asserts asynchronously. Its release is synchronised inside the block, so the internal reset lets go two clock edges after `rst_n` rises.

Top module: `spk_sysctl_port`

## Requirements
- R1: While reset is active, and right after it releases, `timer_gate[2]` is 0, `spk_enable` is 0 and `rd_data` is 0x00. Asserting `rst_n` low clears these outputs at once, without waiting for a clock edge.
- R2: On a rising clock edge with `wr_stb` high, `wr_data[0]` is loaded into `timer_gate[2]` and `wr_data[1]` is loaded into `spk_enable`. Both are visible after that edge. Bits 7..2 of the write data have no effect.
- R3: With `wr_stb` low, `timer_gate[2]` and `spk_enable` keep their values.
- R4: On a rising edge with `rd_stb` high, `rd_data` is loaded as follows:
  - bit 0 is the channel 2 gate;
  - bit 1 is the speaker enable;
  - bit 4 is the refresh indicator;
  - bit 5 is `ch2_out` as sampled at that edge;
  - bits 2, 3, 6 and 7 are 0.
- R5: With `rd_stb` low, `rd_data` holds the last captured byte.
- R6: The refresh indicator starts at 0 after reset and inverts once every `REFRESH_TERM` clock cycles.
- R7: `spk_drive` equals `ch2_out AND spk_enable` combinationally.
- R8: When `rd_stb` and `wr_stb` are high on the same edge, the captured bits 0 and 1 are the gate and enable values from before that write.
- R9: `timer_gate[0]` and `timer_gate[1]` are always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, release is synchronised inside |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| wr_data | input | 8 | Host write data |
| ch2_out | input | 1 | Output level of timer channel 2, synchronous to `clk` |
| timer_gate | output | 3 | Gate inputs for timer channels 2..0 |
| spk_enable | output | 1 | Speaker data enable |
| rd_data | output | 8 | Status byte captured on the last read |
| spk_drive | output | 1 | Channel 2 output masked by the speaker enable |

## Verification
The assertions take for granted two things about the inputs. First, `ch2_out`, `wr_stb`, `rd_stb` and `wr_data` change only in the `clk` domain, so their values at the sampling edge are settled. Second, `REFRESH_TERM` is at least 2. The bench drives every input on the falling edge, which places each input change half a period away from the capture edge. It also keeps the default divider term, so a single run can measure a full refresh half-period.

// File: rtl/spk_sysctl_pkg.sv
package spk_sysctl_pkg;

  localparam int unsigned BYTE_W = 8;

  // write data field positions
  localparam int unsigned WB_GATE = 0;
  localparam int unsigned WB_SPKEN = 1;

  // status byte field positions
  localparam int unsigned SB_GATE = 0;
  localparam int unsigned SB_SPKEN = 1;
  localparam int unsigned SB_REFRESH = 4;
  localparam int unsigned SB_CH2OUT = 5;

  typedef struct packed {
    logic spk_en;
    logic gate2;
  } ctl_bits_t;

endpackage

// File: rtl/spk_rst_sync.sv
module spk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/spk_refresh_div.sv
module spk_refresh_div #(
  parameter int unsigned TERM = 4096
) (
  input  logic clk,
  input  logic rst_sn,
  output logic refresh
);

  localparam int unsigned CW = (TERM > 2) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic tgl_q, tgl_d;
  logic wrap;

  always_comb begin
    wrap = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    tgl_d = wrap ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign refresh = tgl_q;

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= LAST);
  p_steady_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt_q != LAST) |=> $stable(tgl_q));
  p_flip_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt_q == LAST) |=> (tgl_q != $past(tgl_q)));

endmodule

// File: rtl/spk_ctl_reg.sv
module spk_ctl_reg
  import spk_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  output ctl_bits_t         ctl
);

  ctl_bits_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_stb) begin
      ctl_d.gate2 = wr_data[WB_GATE];
      ctl_d.spk_en = wr_data[WB_SPKEN];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stb |=> (ctl_q.gate2 == $past(wr_data[WB_GATE])) &&
               (ctl_q.spk_en == $past(wr_data[WB_SPKEN])));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_stb |=> $stable(ctl_q));

endmodule

// File: rtl/spk_rd_capture.sv
module spk_rd_capture
  import spk_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              rd_stb,
  input  ctl_bits_t         ctl,
  input  logic              refresh,
  input  logic              ch2_out,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] stat_q, stat_d, stat_now;

  always_comb begin
    stat_now = '0;
    stat_now[SB_GATE] = ctl.gate2;
    stat_now[SB_SPKEN] = ctl.spk_en;
    stat_now[SB_REFRESH] = refresh;
    stat_now[SB_CH2OUT] = ch2_out;
    stat_d = rd_stb ? stat_now : stat_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign rd_data = stat_q;

  p_zero_bits_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_q[7:6] == 2'b00) && (stat_q[3:2] == 2'b00));
  p_ch2_sample_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_stb |=> (stat_q[SB_CH2OUT] == $past(ch2_out)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_stb |=> $stable(stat_q));
  p_old_state_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_stb |=> (stat_q[SB_GATE] == $past(ctl.gate2)) &&
               (stat_q[SB_SPKEN] == $past(ctl.spk_en)));

endmodule

// File: rtl/spk_sysctl_port.sv
module spk_sysctl_port
  import spk_sysctl_pkg::*;
#(
  parameter int unsigned REFRESH_TERM = 4096,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ch2_out,
  output logic [NUM_CH-1:0] timer_gate,
  output logic              spk_enable,
  output logic [BYTE_W-1:0] rd_data,
  output logic              spk_drive
);

  localparam int unsigned CTL_CH = NUM_CH - 1;

  logic rst_sn;
  logic refresh;
  ctl_bits_t ctl;

  spk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  spk_refresh_div #(.TERM(REFRESH_TERM)) u_div (
    .clk(clk), .rst_sn(rst_sn), .refresh(refresh)
  );

  spk_ctl_reg u_ctl (
    .clk(clk), .rst_sn(rst_sn), .wr_stb(wr_stb), .wr_data(wr_data), .ctl(ctl)
  );

  spk_rd_capture u_rd (
    .clk(clk), .rst_sn(rst_sn), .rd_stb(rd_stb), .ctl(ctl),
    .refresh(refresh), .ch2_out(ch2_out), .rd_data(rd_data)
  );

  // R9: channels below the controlled one keep their gates high
  for (genvar g = 0; g < CTL_CH; g++) begin : g_fixed_gate
    assign timer_gate[g] = 1'b1;
  end
  assign timer_gate[CTL_CH] = ctl.gate2;

  assign spk_enable = ctl.spk_en;
  assign spk_drive = ch2_out & ctl.spk_en; // R7

endmodule

// File: tb/tb_spk_sysctl_port.sv
module tb_spk_sysctl_port;

  localparam int TERM = 4096;
  localparam int NV = 12;
  // {wr, rd, wdata[7:0], ch2, exp_gate, exp_en, exp_rd[7:0]}
  localparam logic [20:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h21},
    {1'b1, 1'b0, 8'hFE, 1'b1, 1'b0, 1'b1, 8'h21},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02},
    {1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 1'b1, 8'h02},
    {1'b1, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1, 8'h22},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h23},
    {1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03},
    {1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'hFC, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ch2_out = 1'b0;
  logic [2:0] timer_gate;
  logic spk_enable;
  logic [7:0] rd_data;
  logic spk_drive;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spk_sysctl_port #(.REFRESH_TERM(TERM)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .ch2_out(ch2_out), .timer_gate(timer_gate),
    .spk_enable(spk_enable), .rd_data(rd_data), .spk_drive(spk_drive)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_stb = 1'b0;
    rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t_first;
    int t_second;
    logic prev;

    // reset state
    repeat (2) @(negedge clk);
    #1;
    check("R1 gate2 in reset", int'(timer_gate[2]), 0);
    check("R1 enable in reset", int'(spk_enable), 0);
    check("R1 rd_data in reset", int'(rd_data), 0);
    check("R9 fixed gates in reset", int'(timer_gate[1:0]), 3);
    do_reset();
    check("R1 gate2 after release", int'(timer_gate[2]), 0);
    check("R1 enable after release", int'(spk_enable), 0);
    check("R1 rd_data after release", int'(rd_data), 0);

    // vector table: driven on negedge, checked at the following negedge
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      wr_stb = v[20];
      rd_stb = v[19];
      wr_data = v[18:11];
      ch2_out = v[10];
      @(negedge clk);
      #1;
      check($sformatf("R2 R3 gate vec%0d", i), int'(timer_gate[2]), int'(v[9]));
      check($sformatf("R2 R3 enable vec%0d", i), int'(spk_enable), int'(v[8]));
      check($sformatf("R4 R5 R8 rd_data vec%0d", i), int'(rd_data & 8'hEF), int'(v[7:0]));
      check($sformatf("R7 spk_drive vec%0d", i), int'(spk_drive), int'(v[10] & v[8]));
      check($sformatf("R9 fixed gates vec%0d", i), int'(timer_gate[1:0]), 3);
    end
    wr_stb = 1'b0;
    rd_stb = 1'b0;

    // R7: speaker drive follows ch2_out between edges
    ch2_out = 1'b0;
    #0.5;
    check("R7 drive low with ch2 low", int'(spk_drive), 0);
    ch2_out = 1'b1;
    #0.5;
    check("R7 drive high with ch2 high", int'(spk_drive), 1);

    // R1: asynchronous clear mid-cycle
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear enable", int'(spk_enable), 0);
    check("R1 async clear rd_data", int'(rd_data), 0);
    check("R9 gates during reset", int'(timer_gate), 3);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ch2_out = 1'b0;

    // R6: refresh indicator, read on every cycle
    rd_stb = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R6 refresh starts low", int'(rd_data[4]), 0);
    prev = rd_data[4];
    t_first = -1;
    t_second = -1;
    for (int c = 0; c < 3 * TERM && t_second < 0; c++) begin
      @(negedge clk);
      #1;
      if (rd_data[4] != prev) begin
        if (t_first < 0) t_first = c;
        else t_second = c;
        prev = rd_data[4];
      end
    end
    check("R6 first toggle seen", int'(t_first >= 0), 1);
    check("R6 half-period length", t_second - t_first, TERM);
    check("R6 level after two toggles", int'(rd_data[4]), 0);
    rd_stb = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule